// File: doc/BRIEF.md
# Random Generator Register Front End

This block is the 32-bit memory-mapped register file in front of a random number generator. It decodes word-aligned reads and writes from a simple valid/address/data bus, holds the control, extended control, seed, personalization, oscillator-enable, interrupt-control and mask registers, and hands their contents and write strobes to the generator and interrupt logic that sit outside it. Every access is answered one cycle after it is presented.

Two things set it apart from a plain register file. Seed and personalization words are secret: any read in the window 0x40 to 0xAC returns the status word instead of the stored value. The set of writable control bits, and whether the three extended control registers accept writes at all, depends on a hardware-version input sampled on every write. A write that moves the reset register bit from 0 to 1 returns every register to its reset value and raises a one-cycle soft-reset pulse towards the generator.

Top module: `rng_reg_front`

## Requirements
- R1: After reset, 0x0C reads 0x0000_210C, 0x10 reads 0x0002_6F09, 0xD0 reads 0x1, 0xE4 reads 0x3 and 0x08 reads 0.
- R2: An access is taken only with all four byte enables set and address bits 1:0 zero; any other write changes nothing and any other read returns 0.
- R3: A read at any address from 0x40 through 0xAC, including the unused gap 0x70 to 0x7C, returns the status word; 0xB0 is outside the window and reads 0.
- R4: When the version input is below 0x0200, a write to control (0x08) stores bits 10 and 9 as zero, and writes to 0x0C, 0x10 and 0x14 are dropped with no strobe.
- R5: When the version input is 0x0200 or above, a write to control stores bits 4 and 1 as zero, and 0x0C, 0x10 and 0x14 are writable.
- R6: Status (0x04) bits 11:0 always reflect the status input; a bus write affects only bits 31:12.
- R7: A read of 0xC0 returns the generator data input and raises the read strobe for exactly the following cycle; a write to 0xC0 stores nothing and raises no strobe.
- R8: A write with bit 0 set to 0xD0 while its stored bit is 0 restores every register, including seeds and personalization, to its reset value and pulses the soft-reset output for one cycle; the same write while the bit is already 1 has no effect.
- R9: The in-reset output is high exactly while the reset register bit or control bit 0 is set.
- R10: The mask at 0xE4 (bits 1:0) is read-only; writing 0xE8 clears the mask bits set in the data, writing 0xEC sets them.
- R11: Seed word k (address 0x40+4k) and personalization word k (address 0x80+4k) appear on bits 32k+31:32k of their outputs; the oscillator enable at 0xD4 bit 0 reads back and drives its output.
- R12: Accepted writes to 0x00, 0x08 and 0x14 raise their write strobe for the cycle after the write, in which the register output already holds the filtered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_version_i | input | 16 | Hardware version selecting the write filter |
| req_valid_i | input | 1 | Access presented this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address |
| req_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata_i | input | 32 | Write data |
| status_i | input | 12 | Hardware status bits 11:0 |
| rng_data_i | input | 32 | Generator output word |
| rdata_o | output | 32 | Read data, one cycle after the read |
| core_rd_o | output | 1 | One-cycle strobe after a read of 0xC0 |
| intctl_o | output | 32 | Interrupt-control register |
| intctl_wr_o | output | 1 | Strobe after a write to 0x00 |
| ctrl_o | output | 32 | Control register |
| ctrl_wr_o | output | 1 | Strobe after a write to 0x08 |
| ctrl2_o | output | 32 | Extended control register 0x0C |
| ctrl3_o | output | 32 | Extended control register 0x10 |
| ctrl4_o | output | 32 | Extended control register 0x14 |
| ctrl4_wr_o | output | 1 | Strobe after an accepted write to 0x14 |
| seed_o | output | 384 | Twelve seed words |
| pers_o | output | 384 | Twelve personalization words |
| osc_en_o | output | 1 | Oscillator enable |
| imask_o | output | 2 | Interrupt mask |
| in_reset_o | output | 1 | Block held in reset |
| soft_rst_o | output | 1 | One-cycle pulse on a full reset |

## Verification
A wrong decode or filter shows on the very next read of the affected address, since every read is registered one cycle after it is presented; a control bit that escapes the version filter is visible on the control output in the same cycle its write strobe rises. A broken secret window leaks the stored seed on the read port one cycle after a read in 0x40 to 0xAC. A missed or spurious full reset appears at once on the soft-reset and in-reset outputs, and on the next read of the extended control registers and mask.

// File: rtl/rng_reg_pkg.sv
package rng_reg_pkg;
  localparam int DATA_W = 32;
  localparam int STAT_HW_W = 12;

  localparam int ADDR_INTCTL = 'h00;
  localparam int ADDR_STATUS = 'h04;
  localparam int ADDR_CTRL = 'h08;
  localparam int ADDR_CTRL2 = 'h0C;
  localparam int ADDR_CTRL3 = 'h10;
  localparam int ADDR_CTRL4 = 'h14;
  localparam int ADDR_SEED = 'h40;
  localparam int ADDR_PERS = 'h80;
  localparam int ADDR_CORE = 'hC0;
  localparam int ADDR_RST = 'hD0;
  localparam int ADDR_OSC = 'hD4;
  localparam int ADDR_MASK = 'hE4;
  localparam int ADDR_MCLR = 'hE8;
  localparam int ADDR_MSET = 'hEC;

  localparam logic [DATA_W-1:0] CTRL2_RST = 32'h0000_210C;
  localparam logic [DATA_W-1:0] CTRL3_RST = 32'h0002_6F09;
  localparam logic [1:0] MASK_RST = 2'b11;

  // control bits forced low per version class
  localparam logic [DATA_W-1:0] CTRL_OLD_CLR = 32'h0000_0600;
  localparam logic [DATA_W-1:0] CTRL_NEW_CLR = 32'h0000_0012;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_INTCTL, SEL_STATUS, SEL_CTRL, SEL_CTRL2, SEL_CTRL3,
    SEL_CTRL4, SEL_SEED, SEL_PERS, SEL_CORE, SEL_RST, SEL_OSC,
    SEL_MASK, SEL_MCLR, SEL_MSET
  } reg_sel_e;
endpackage

// File: rtl/rng_bus_decode.sv
module rng_bus_decode
  import rng_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_WORDS = 12,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic              acc_ok_o,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              secret_o
);
  localparam int BANK_BYTES = 4 * NUM_WORDS;
  int addr_int;

  always_comb begin
    addr_int = int'(addr_i);
    acc_ok_o = valid_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00);
    secret_o = (addr_int >= ADDR_SEED) && (addr_int <= ADDR_PERS + BANK_BYTES - 4);
    sel_o = SEL_NONE;
    idx_o = '0;
    if (addr_int >= ADDR_SEED && addr_int < ADDR_SEED + BANK_BYTES) begin
      sel_o = SEL_SEED;
      idx_o = IDX_W'((addr_int - ADDR_SEED) >> 2);
    end else if (addr_int >= ADDR_PERS && addr_int < ADDR_PERS + BANK_BYTES) begin
      sel_o = SEL_PERS;
      idx_o = IDX_W'((addr_int - ADDR_PERS) >> 2);
    end else begin
      case (addr_int)
        ADDR_INTCTL: sel_o = SEL_INTCTL;
        ADDR_STATUS: sel_o = SEL_STATUS;
        ADDR_CTRL:   sel_o = SEL_CTRL;
        ADDR_CTRL2:  sel_o = SEL_CTRL2;
        ADDR_CTRL3:  sel_o = SEL_CTRL3;
        ADDR_CTRL4:  sel_o = SEL_CTRL4;
        ADDR_CORE:   sel_o = SEL_CORE;
        ADDR_RST:    sel_o = SEL_RST;
        ADDR_OSC:    sel_o = SEL_OSC;
        ADDR_MASK:   sel_o = SEL_MASK;
        ADDR_MCLR:   sel_o = SEL_MCLR;
        ADDR_MSET:   sel_o = SEL_MSET;
        default:     sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/rng_wr_filter.sv
module rng_wr_filter
  import rng_reg_pkg::*;
#(
  parameter int VERSION_W = 16,
  parameter int GATE_VERSION = 'h0200
) (
  input  logic [VERSION_W-1:0] hw_version_i,
  input  reg_sel_e             sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    wdata_o,
  output logic                 drop_o,
  output logic                 hw_old_o
);
  always_comb begin
    hw_old_o = hw_version_i < VERSION_W'(GATE_VERSION);
    wdata_o = wdata_i;
    drop_o = 1'b0;
    if (hw_old_o) begin
      if (sel_i == SEL_CTRL) wdata_o = wdata_i & ~CTRL_OLD_CLR;
      if (sel_i inside {SEL_CTRL2, SEL_CTRL3, SEL_CTRL4}) drop_o = 1'b1;
    end else if (sel_i == SEL_CTRL) begin
      wdata_o = wdata_i & ~CTRL_NEW_CLR;
    end
  end
endmodule

// File: rtl/rng_secret_bank.sv
module rng_secret_bank
  import rng_reg_pkg::*;
#(
  parameter int NUM_WORDS = 12,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_WORDS*DATA_W-1:0] words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (clear_i) word_q <= '0;
      else if (we_i && idx_i == IDX_W'(g)) word_q <= wdata_i;
    end
    assign words_o[g*DATA_W +: DATA_W] = word_q;
  end

  // R8: full reset wipes the bank
  p_bank_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (words_o == '0));
endmodule

// File: rtl/rng_reg_front.sv
module rng_reg_front
  import rng_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VERSION_W = 16,
  parameter int GATE_VERSION = 'h0200,
  parameter int NUM_WORDS = 12,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int BANK_W = NUM_WORDS * DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VERSION_W-1:0] hw_version_i,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [3:0]           req_be_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic [STAT_HW_W-1:0] status_i,
  input  logic [DATA_W-1:0]    rng_data_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 core_rd_o,
  output logic [DATA_W-1:0]    intctl_o,
  output logic                 intctl_wr_o,
  output logic [DATA_W-1:0]    ctrl_o,
  output logic                 ctrl_wr_o,
  output logic [DATA_W-1:0]    ctrl2_o,
  output logic [DATA_W-1:0]    ctrl3_o,
  output logic [DATA_W-1:0]    ctrl4_o,
  output logic                 ctrl4_wr_o,
  output logic [BANK_W-1:0]    seed_o,
  output logic [BANK_W-1:0]    pers_o,
  output logic                 osc_en_o,
  output logic [1:0]           imask_o,
  output logic                 in_reset_o,
  output logic                 soft_rst_o
);
  localparam int STAT_SW_W = DATA_W - STAT_HW_W;

  logic acc_ok, rd_secret, drop, hw_old;
  reg_sel_e sel;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] wdata_f, status_word, rd_mux;
  logic wr_go, rd_go, full_rst;

  logic [DATA_W-1:0] intctl_q, ctrl_q, ctrl2_q, ctrl3_q, ctrl4_q, rdata_q;
  logic [STAT_SW_W-1:0] stat_hi_q;
  logic rst_q, osc_q, core_rd_q, soft_rst_q, ctrl_wr_q, ctrl4_wr_q, intctl_wr_q;
  logic [1:0] imask_q;

  rng_bus_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .valid_i(req_valid_i), .addr_i(req_addr_i), .be_i(req_be_i),
    .acc_ok_o(acc_ok), .sel_o(sel), .idx_o(idx), .secret_o(rd_secret)
  );

  rng_wr_filter #(.VERSION_W(VERSION_W), .GATE_VERSION(GATE_VERSION)) u_filter (
    .hw_version_i(hw_version_i), .sel_i(sel), .wdata_i(req_wdata_i),
    .wdata_o(wdata_f), .drop_o(drop), .hw_old_o(hw_old)
  );

  assign wr_go = acc_ok && req_write_i && !drop;
  assign rd_go = acc_ok && !req_write_i;
  // only a 0->1 transition of the reset bit triggers the full reset
  assign full_rst = wr_go && (sel == SEL_RST) && wdata_f[0] && !rst_q;
  assign status_word = {stat_hi_q, status_i};

  rng_secret_bank #(.NUM_WORDS(NUM_WORDS)) u_seed (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(full_rst),
    .we_i(wr_go && sel == SEL_SEED && !full_rst), .idx_i(idx), .wdata_i(wdata_f),
    .words_o(seed_o)
  );

  rng_secret_bank #(.NUM_WORDS(NUM_WORDS)) u_pers (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(full_rst),
    .we_i(wr_go && sel == SEL_PERS && !full_rst), .idx_i(idx), .wdata_i(wdata_f),
    .words_o(pers_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intctl_q    <= '0;
      stat_hi_q   <= '0;
      ctrl_q      <= '0;
      ctrl2_q     <= CTRL2_RST;
      ctrl3_q     <= CTRL3_RST;
      ctrl4_q     <= '0;
      rst_q       <= 1'b1;
      osc_q       <= 1'b0;
      imask_q     <= MASK_RST;
      soft_rst_q  <= 1'b0;
      ctrl_wr_q   <= 1'b0;
      ctrl4_wr_q  <= 1'b0;
      intctl_wr_q <= 1'b0;
    end else begin
      soft_rst_q  <= 1'b0;
      ctrl_wr_q   <= 1'b0;
      ctrl4_wr_q  <= 1'b0;
      intctl_wr_q <= 1'b0;
      if (full_rst) begin
        intctl_q   <= '0;
        stat_hi_q  <= '0;
        ctrl_q     <= '0;
        ctrl2_q    <= CTRL2_RST;
        ctrl3_q    <= CTRL3_RST;
        ctrl4_q    <= '0;
        rst_q      <= 1'b1;
        osc_q      <= 1'b0;
        imask_q    <= MASK_RST;
        soft_rst_q <= 1'b1;
      end else if (wr_go) begin
        unique case (sel)
          SEL_INTCTL: begin intctl_q <= wdata_f; intctl_wr_q <= 1'b1; end
          SEL_STATUS: stat_hi_q <= wdata_f[DATA_W-1:STAT_HW_W];
          SEL_CTRL:   begin ctrl_q <= wdata_f; ctrl_wr_q <= 1'b1; end
          SEL_CTRL2:  ctrl2_q <= wdata_f;
          SEL_CTRL3:  ctrl3_q <= wdata_f;
          SEL_CTRL4:  begin ctrl4_q <= wdata_f; ctrl4_wr_q <= 1'b1; end
          SEL_RST:    rst_q <= wdata_f[0];
          SEL_OSC:    osc_q <= wdata_f[0];
          SEL_MCLR:   imask_q <= imask_q & ~wdata_f[1:0];
          SEL_MSET:   imask_q <= imask_q | wdata_f[1:0];
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_secret) rd_mux = status_word;
    else begin
      unique case (sel)
        SEL_INTCTL: rd_mux = intctl_q;
        SEL_STATUS: rd_mux = status_word;
        SEL_CTRL:   rd_mux = ctrl_q;
        SEL_CTRL2:  rd_mux = ctrl2_q;
        SEL_CTRL3:  rd_mux = ctrl3_q;
        SEL_CTRL4:  rd_mux = ctrl4_q;
        SEL_CORE:   rd_mux = rng_data_i;
        SEL_RST:    rd_mux = {{(DATA_W-1){1'b0}}, rst_q};
        SEL_OSC:    rd_mux = {{(DATA_W-1){1'b0}}, osc_q};
        SEL_MASK:   rd_mux = {{(DATA_W-2){1'b0}}, imask_q};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      core_rd_q <= 1'b0;
    end else begin
      core_rd_q <= rd_go && (sel == SEL_CORE);
      if (rd_go) rdata_q <= rd_mux;
      else if (req_valid_i && !req_write_i) rdata_q <= '0;
    end
  end

  assign rdata_o     = rdata_q;
  assign core_rd_o   = core_rd_q;
  assign intctl_o    = intctl_q;
  assign intctl_wr_o = intctl_wr_q;
  assign ctrl_o      = ctrl_q;
  assign ctrl_wr_o   = ctrl_wr_q;
  assign ctrl2_o     = ctrl2_q;
  assign ctrl3_o     = ctrl3_q;
  assign ctrl4_o     = ctrl4_q;
  assign ctrl4_wr_o  = ctrl4_wr_q;
  assign osc_en_o    = osc_q;
  assign imask_o     = imask_q;
  assign in_reset_o  = rst_q | ctrl_q[0];
  assign soft_rst_o  = soft_rst_q;

  p_bad_read_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && !req_write_i && !acc_ok) |-> (rdata_q == '0));

  p_secret_hidden_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_go && rd_secret) |-> (rdata_q == $past(status_word)));

  p_old_ctrl_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_q && $past(hw_old)) |-> (ctrl_q[10:9] == 2'b00));

  p_old_ext_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl4_wr_q |-> !$past(hw_old));

  p_new_ctrl_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_q && !$past(hw_old)) |-> (ctrl_q[4] == 1'b0 && ctrl_q[1] == 1'b0));

  p_core_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rd_q |-> ($past(rd_go && sel == SEL_CORE) && rdata_q == $past(rng_data_i)));

  p_full_rst_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_q |-> (!$past(rst_q) && rst_q && ctrl2_q == CTRL2_RST && imask_q == MASK_RST));

  p_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_rst_q) |-> in_reset_o);
endmodule

// File: tb/tb_rng_reg_front.sv
module tb_rng_reg_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] hw_version = 16'h0200;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic [11:0] status = 12'h5A3;
  logic [31:0] rng_data = '0;

  logic [31:0] rdata, intctl, ctrl, ctrl2, ctrl3, ctrl4;
  logic core_rd, intctl_wr, ctrl_wr, ctrl4_wr, osc_en, in_reset, soft_rst;
  logic [383:0] seed, pers;
  logic [1:0] imask;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rng_reg_front dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_version_i(hw_version),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_be_i(req_be), .req_wdata_i(req_wdata), .status_i(status),
    .rng_data_i(rng_data), .rdata_o(rdata), .core_rd_o(core_rd),
    .intctl_o(intctl), .intctl_wr_o(intctl_wr), .ctrl_o(ctrl), .ctrl_wr_o(ctrl_wr),
    .ctrl2_o(ctrl2), .ctrl3_o(ctrl3), .ctrl4_o(ctrl4), .ctrl4_wr_o(ctrl4_wr),
    .seed_o(seed), .pers_o(pers), .osc_en_o(osc_en), .imask_o(imask),
    .in_reset_o(in_reset), .soft_rst_o(soft_rst)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h0C, 4'hF, 32'h0, 32'h0000_210C, 4'd1},  // R1
    '{1'b0, 8'h10, 4'hF, 32'h0, 32'h0002_6F09, 4'd1},  // R1
    '{1'b0, 8'hD0, 4'hF, 32'h0, 32'h1, 4'd1},          // R1
    '{1'b0, 8'hE4, 4'hF, 32'h0, 32'h3, 4'd1},          // R1
    '{1'b0, 8'h08, 4'hF, 32'h0, 32'h0, 4'd1},          // R1
    '{1'b1, 8'hD0, 4'hF, 32'h0, 32'h0, 4'd0},
    '{1'b0, 8'hD0, 4'hF, 32'h0, 32'h0, 4'd8},          // R8 bit clears without reset
    '{1'b1, 8'h08, 4'hF, 32'hFFFF_FFFE, 32'h0, 4'd0},
    '{1'b0, 8'h08, 4'hF, 32'h0, 32'hFFFF_FFEC, 4'd5},  // R5 bits 4,1 dropped
    '{1'b1, 8'h0C, 4'hF, 32'h1234, 32'h0, 4'd0},
    '{1'b0, 8'h0C, 4'hF, 32'h0, 32'h1234, 4'd5},       // R5
    '{1'b1, 8'h40, 4'hF, 32'hDEAD_BEEF, 32'h0, 4'd0},
    '{1'b0, 8'h40, 4'hF, 32'h0, 32'h0000_05A3, 4'd3},  // R3
    '{1'b0, 8'hAC, 4'hF, 32'h0, 32'h0000_05A3, 4'd3},  // R3 top of window
    '{1'b0, 8'h74, 4'hF, 32'h0, 32'h0000_05A3, 4'd3},  // R3 gap
    '{1'b0, 8'hB0, 4'hF, 32'h0, 32'h0, 4'd3},          // R3 past window
    '{1'b1, 8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 8'h04, 4'hF, 32'h0, 32'hFFFF_F5A3, 4'd6},  // R6
    '{1'b1, 8'h10, 4'h3, 32'hAB, 32'h0, 4'd0},
    '{1'b0, 8'h10, 4'hF, 32'h0, 32'h0002_6F09, 4'd2},  // R2 narrow write ignored
    '{1'b0, 8'h0D, 4'hF, 32'h0, 32'h0, 4'd2},          // R2 unaligned read
    '{1'b0, 8'h0C, 4'h1, 32'h0, 32'h0, 4'd2},          // R2 narrow read
    '{1'b1, 8'hE8, 4'hF, 32'h1, 32'h0, 4'd0},
    '{1'b0, 8'hE4, 4'hF, 32'h0, 32'h2, 4'd10},         // R10 clear
    '{1'b1, 8'hE4, 4'hF, 32'h3, 32'h0, 4'd0},
    '{1'b0, 8'hE4, 4'hF, 32'h0, 32'h2, 4'd10},         // R10 read-only
    '{1'b1, 8'hEC, 4'hF, 32'h1, 32'h0, 4'd0},
    '{1'b0, 8'hE4, 4'hF, 32'h0, 32'h3, 4'd10},         // R10 set
    '{1'b1, 8'hD4, 4'hF, 32'h1, 32'h0, 4'd0},
    '{1'b0, 8'hD4, 4'hF, 32'h0, 32'h1, 4'd11}          // R11 oscillator enable
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 in reset after reset", {31'b0, in_reset}, 32'h1);
    chk("R8 no soft reset pulse", {31'b0, soft_rst}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].data, VECS[i].be);
      else begin
        bus_rd(VECS[i].addr, VECS[i].be, d);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end

    chk("R11 osc enable output", {31'b0, osc_en}, 32'h1);
    chk("R9 released", {31'b0, in_reset}, 32'h0);
    bus_wr(8'h08, 32'h1, 4'hF);
    chk("R12 ctrl strobe", {31'b0, ctrl_wr}, 32'h1);
    chk("R9 ctrl bit 0", {31'b0, in_reset}, 32'h1);
    @(negedge clk);
    chk("R12 ctrl strobe one cycle", {31'b0, ctrl_wr}, 32'h0);
    bus_wr(8'h08, 32'h0, 4'hF);
    chk("R9 ctrl bit 0 cleared", {31'b0, in_reset}, 32'h0);
    bus_wr(8'h00, 32'h5, 4'hF);
    chk("R12 intctl strobe", {31'b0, intctl_wr}, 32'h1);
    chk("R12 intctl value", intctl, 32'h5);
    bus_wr(8'h14, 32'h1, 4'hF);
    chk("R12 ctrl4 strobe new version", {31'b0, ctrl4_wr}, 32'h1);
    chk("R12 ctrl4 value", ctrl4, 32'h1);

    chk("R11 seed word 0", seed[31:0], 32'hDEAD_BEEF);
    bus_wr(8'hAC, 32'h77, 4'hF);
    chk("R11 pers word 11", pers[383:352], 32'h77);
    chk("R11 pers word 0 untouched", pers[31:0], 32'h0);

    rng_data = 32'hCAFE_F00D;
    bus_rd(8'hC0, 4'hF, d);
    chk("R7 core data", d, 32'hCAFE_F00D);
    chk("R7 core strobe", {31'b0, core_rd}, 32'h1);
    @(negedge clk);
    chk("R7 core strobe one cycle", {31'b0, core_rd}, 32'h0);
    bus_wr(8'hC0, 32'h1, 4'hF);
    chk("R7 write gives no strobe", {31'b0, core_rd}, 32'h0);

    hw_version = 16'h01FF;
    bus_wr(8'h08, 32'hFFFF_FFFE, 4'hF);
    bus_rd(8'h08, 4'hF, d);
    chk("R4 ctrl bits 10,9 dropped", d, 32'hFFFF_F9FE);
    bus_wr(8'h14, 32'h3, 4'hF);
    chk("R4 ctrl4 no strobe", {31'b0, ctrl4_wr}, 32'h0);
    bus_rd(8'h14, 4'hF, d);
    chk("R4 ctrl4 write dropped", d, 32'h1);
    bus_wr(8'h0C, 32'h99, 4'hF);
    bus_rd(8'h0C, 4'hF, d);
    chk("R4 ctrl2 write dropped", d, 32'h1234);

    bus_wr(8'hD0, 32'h1, 4'hF);
    chk("R8 soft reset pulse", {31'b0, soft_rst}, 32'h1);
    chk("R8 in reset", {31'b0, in_reset}, 32'h1);
    chk("R8 seed cleared", seed[31:0], 32'h0);
    chk("R8 pers cleared", pers[383:352], 32'h0);
    bus_rd(8'h0C, 4'hF, d);
    chk("R8 ctrl2 restored", d, 32'h0000_210C);
    bus_rd(8'hE4, 4'hF, d);
    chk("R8 mask restored", d, 32'h3);
    bus_rd(8'h04, 4'hF, d);
    chk("R8 status upper restored", d, 32'h0000_05A3);
    bus_rd(8'h08, 4'hF, d);
    chk("R8 ctrl restored", d, 32'h0);

    hw_version = 16'h0200;
    bus_wr(8'h0C, 32'h55, 4'hF);
    bus_wr(8'hD0, 32'h1, 4'hF);
    chk("R8 repeated 1 no pulse", {31'b0, soft_rst}, 32'h0);
    bus_rd(8'h0C, 4'hF, d);
    chk("R8 repeated 1 keeps state", d, 32'h55);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule